// File: doc/BRIEF.md
# Regulator power-up and shutdown sequencer

This block decides when each of seven regulator rails of a power-management unit is switched on or off. A start request from any of three wake sources brings the rails up one after another. Each step waits for the power-good flag of the rail before it. The block then holds the system reset low for a fixed time after the core rail is good, and keeps the unit alive only while the two required rails stay in regulation. Software takes over some rails through a hold handshake. A thermal event or the loss of a required rail drops everything at once. A clean shutdown takes the rails down in the reverse of their start-up order.

Rail numbering in this brief: rail index i (bit i of `rail_en`) is regulator i+1. Rail 0 is the core rail and rail 1 is the logic rail, and both are required. Rail 2 is the analog rail. Rails 3 to 5 follow the external pins `ext_en[0..2]`. Rail 6 is the general-purpose rail. Register bits arrive as the plain input `reg_en`: bit 0 controls rail 0, bit 1 controls rail 2 and bit 2 controls rail 6. The register outside the block resets to rails 0 and 2 on and rail 6 off. All controls are level signals, and the block has no streaming interface.

Top module: `pwr_seq_top`

## Requirements
- R1: Start-up begins only from the powered-down state, when at least one of `wake_key`, `wake_hf` or `wake_chg` is high, `uvlo_ok` is high and `tsd` is low. Rail 0 is then enabled on the next clock edge. While `uvlo_ok` is low no rail turns on.
- R2: Rail 1 is enabled only after `pgood[0]` has been seen. Rail 2 is enabled only after `pgood[1]` has been seen, so the rails rise in the order 0, 1, 2.
- R3: On the edge that enables rail 2, rails 3 to 5 are enabled for each `ext_en` bit that is high. From then on, and while running, each of these rails follows its pin one cycle later.
- R4: `rst_out_n` is low during power-up. It rises exactly `RST_DLY_CYC` cycles after the core-rail good flag `pgood[0]` is first seen high.
- R5: If `pgood[1]` falls after rail 1 has come up, while the unit is starting or running, all rails are off on the next edge and `pwr_down` is high.
- R6: If rail 0 is enabled and has been good, a fall of `pgood[0]` powers the unit down. Turning rail 0 off through `reg_en[0]` after the hold does not cause a shutdown.
- R7: Before `host_hold` has been seen high in the running state, rails 0 and 2 are on and rail 6 is off, whatever `reg_en` holds. One cycle after the hold is seen, rails 0, 2 and 6 follow `reg_en[0]`, `reg_en[1]` and `reg_en[2]`.
- R8: `key_n` is always the inverse of `wake_key`.
- R9: When `tsd` is high at a clock edge, every rail is off after that edge.
- R10: If `host_hold` has not been seen high within `HOLD_WIN_CYC` cycles after `rst_out_n` rises, the unit shuts down. Rail 1 falls exactly `HOLD_WIN_CYC`+3 cycles after `rst_out_n` rose.
- R11: When `host_hold` drops after being seen, with no wake source high, the rails go off in reverse order, one cycle apart: rails 3 to 6 first, then rail 2, then rail 1, then rail 0.
- R12: After any shutdown the block stays down, even with a wake source high, until all wake sources have been low at the same time. A new wake then starts it again.
- R13: While `pwr_down` is high, all rails are off and `rst_out_n` is low. `pwr_down` is high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| wake_key | input | 1 | Power-key wake source |
| wake_hf | input | 1 | Accessory wake source |
| wake_chg | input | 1 | Charger-present wake source |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| tsd | input | 1 | Thermal shutdown indication |
| pgood | input | 3 | Power-good of rails 0, 1, 2 |
| ext_en | input | 3 | External enable pins for rails 3, 4, 5 |
| host_hold | input | 1 | Host keep-alive handshake |
| reg_en | input | 3 | Register enables for rails 0, 2, 6 |
| rail_en | output | 7 | Regulator enables, bit i is rail i |
| rst_out_n | output | 1 | System reset, active low |
| key_n | output | 1 | Inverted `wake_key` |
| pwr_down | output | 1 | High while the unit is powered down |

## Verification
Some rules are checked by the assertions on every cycle. A thermal indication clears every rail on the next edge. A powered-down unit drives no rail and holds reset. Rail 1 and the pin-controlled rails rise only after the rail before them was good, and reset rises only with the core rail good. A loss of the logic rail while running empties the enables. Only the bench scenarios can show the behaviour that depends on timing windows and on history. This covers the exact reset delay, the hold-window expiry and the one-cycle spacing of the reverse shutdown. It also covers the lockout until the wake sources are released, the handover of rails 0, 2 and 6 to the register bits, and the absence of a shutdown when software turns off the core rail.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NRAIL = 7;
  localparam int NEXT  = 3;
  localparam int NREG  = 3;

  typedef enum logic [2:0] {
    SQ_OFF,
    SQ_UP1,
    SQ_UP2,
    SQ_UP3,
    SQ_RUN,
    SQ_DOWN,
    SQ_LOCK
  } seq_state_e;

  // rails still allowed on at each step of the reverse shutdown
  function automatic logic [NRAIL-1:0] down_keep(input logic [1:0] step);
    case (step)
      2'd0:    return NRAIL'(7'b0000111);
      2'd1:    return NRAIL'(7'b0000011);
      2'd2:    return NRAIL'(7'b0000001);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake (
  input  logic wake_key,
  input  logic wake_hf,
  input  logic wake_chg,
  input  logic uvlo_ok,
  input  logic tsd,
  output logic wake_any,
  output logic start_ok,
  output logic key_n
);
  assign wake_any = wake_key | wake_hf | wake_chg;
  assign start_ok = wake_any & uvlo_ok & ~tsd;
  assign key_n    = ~wake_key;
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (run && !done) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == W'(LIMIT - 1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             wake_any,
  input  logic             uvlo_ok,
  input  logic             tsd,
  input  logic [2:0]       pgood,
  input  logic [NEXT-1:0]  ext_en,
  input  logic [NREG-1:0]  reg_en,
  input  logic             host_hold,
  input  logic             hold_expired,
  output seq_state_e       state,
  output logic             held,
  output logic [NRAIL-1:0] rail_en
);
  seq_state_e       st_d;
  logic [1:0]       step_q, step_d;
  logic             r1_good_q;
  logic [NRAIL-1:0] en_d;
  logic             active, req_fail, trip;

  assign active = (state == SQ_UP1) || (state == SQ_UP2) ||
                  (state == SQ_UP3) || (state == SQ_RUN);

  always_comb begin
    case (state)
      SQ_UP2:  req_fail = !pgood[0];
      SQ_UP3:  req_fail = !pgood[0] || !pgood[1];
      SQ_RUN:  req_fail = !pgood[1] || (r1_good_q && rail_en[0] && !pgood[0]);
      default: req_fail = 1'b0;
    endcase
  end

  assign trip = tsd || (active && (req_fail || !uvlo_ok));

  always_comb begin
    st_d = state;
    if (trip && state != SQ_OFF) begin
      st_d = SQ_LOCK;
    end else begin
      case (state)
        SQ_OFF:  if (start_ok) st_d = SQ_UP1;
        SQ_UP1:  if (pgood[0]) st_d = SQ_UP2;
        SQ_UP2:  if (pgood[1]) st_d = SQ_UP3;
        SQ_UP3:  if (pgood[2]) st_d = SQ_RUN;
        SQ_RUN:  if (hold_expired || (held && !host_hold && !wake_any)) st_d = SQ_DOWN;
        SQ_DOWN: if (step_q == 2'd3) st_d = SQ_LOCK;
        SQ_LOCK: if (!wake_any) st_d = SQ_OFF;
        default: st_d = SQ_OFF;
      endcase
    end
  end

  assign step_d = (st_d == SQ_DOWN && state == SQ_DOWN) ? step_q + 2'd1 : 2'd0;

  always_comb begin
    case (st_d)
      SQ_UP1:  en_d = NRAIL'(7'b0000001);
      SQ_UP2:  en_d = NRAIL'(7'b0000011);
      SQ_UP3:  en_d = {1'b0, ext_en, 3'b111};
      SQ_RUN:  en_d = {held ? reg_en[2] : 1'b0, ext_en,
                       held ? reg_en[1] : 1'b1, 1'b1,
                       held ? reg_en[0] : 1'b1};
      SQ_DOWN: en_d = rail_en & down_keep(step_d);
      default: en_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_OFF;
      step_q    <= 2'd0;
      held      <= 1'b0;
      r1_good_q <= 1'b0;
      rail_en   <= '0;
    end else begin
      state     <= st_d;
      step_q    <= step_d;
      held      <= (state == SQ_RUN) && (held || host_hold);
      r1_good_q <= rail_en[0] && (r1_good_q || pgood[0]);
      rail_en   <= en_d;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int RST_DLY_CYC  = 600000,
  parameter int HOLD_WIN_CYC = 2000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_key,
  input  logic             wake_hf,
  input  logic             wake_chg,
  input  logic             uvlo_ok,
  input  logic             tsd,
  input  logic [2:0]       pgood,
  input  logic [NEXT-1:0]  ext_en,
  input  logic             host_hold,
  input  logic [NREG-1:0]  reg_en,
  output logic [NRAIL-1:0] rail_en,
  output logic             rst_out_n,
  output logic             key_n,
  output logic             pwr_down
);
  seq_state_e state;
  logic wake_any, start_ok, held, active, rst_done, hold_expired;

  pwr_seq_wake u_wake (
    .wake_key (wake_key),
    .wake_hf  (wake_hf),
    .wake_chg (wake_chg),
    .uvlo_ok  (uvlo_ok),
    .tsd      (tsd),
    .wake_any (wake_any),
    .start_ok (start_ok),
    .key_n    (key_n)
  );

  assign active = (state == SQ_UP1) || (state == SQ_UP2) ||
                  (state == SQ_UP3) || (state == SQ_RUN);

  pwr_seq_timer #(.LIMIT(RST_DLY_CYC)) u_rst_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .run   (active && pgood[0]),
    .done  (rst_done)
  );

  pwr_seq_timer #(.LIMIT(HOLD_WIN_CYC)) u_hold_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != SQ_RUN),
    .run   (rst_done && !held),
    .done  (hold_expired)
  );

  pwr_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_ok     (start_ok),
    .wake_any     (wake_any),
    .uvlo_ok      (uvlo_ok),
    .tsd          (tsd),
    .pgood        (pgood),
    .ext_en       (ext_en),
    .reg_en       (reg_en),
    .host_hold    (host_hold),
    .hold_expired (hold_expired),
    .state        (state),
    .held         (held),
    .rail_en      (rail_en)
  );

  assign rst_out_n = rst_done && active;
  assign pwr_down  = (state == SQ_OFF) || (state == SQ_LOCK);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tsd,
  input logic [1:0] pgood,
  input logic [6:0] rail_en,
  input logic       rst_out_n,
  input logic       pwr_down
);
  AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tsd |=> (rail_en == '0)); // R9
  AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (rail_en == '0 && !rst_out_n)); // R13
  AST_LOGIC_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[1]) |-> $past(pgood[0])); // R2
  AST_ANALOG_AFTER_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[2]) |-> $past(pgood[1])); // R2
  for (genvar i = 3; i < 6; i++) begin : g_ext
    AST_EXT_AFTER_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[i]) |-> $past(pgood[1])); // R3
  end
  AST_RST_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(pgood[0])); // R4
  AST_LOGIC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && rail_en[1] && $past(rail_en[1]) && $fell(pgood[1])) |=> (rail_en == '0)); // R5
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tsd       (tsd),
  .pgood     (pgood[1:0]),
  .rail_en   (rail_en),
  .rst_out_n (rst_out_n),
  .pwr_down  (pwr_down)
);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
  localparam int RST_DLY  = 20;
  localparam int HOLD_WIN = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_key = 1'b0, wake_hf = 1'b0, wake_chg = 1'b0;
  logic uvlo_ok = 1'b0, tsd = 1'b0, host_hold = 1'b0;
  logic [2:0] pg_r = '0;
  logic [6:0] fail_mask = '0;
  logic [2:0] ext_en = '0, reg_en = 3'b101;
  logic [6:0] rail_en;
  logic rst_out_n, key_n, pwr_down;

  int errors = 0, checks = 0, cyc = 0;
  int t_rise[7], t_fall[7];
  int t_pg0 = -1, t_rst = -1;
  logic [6:0] prev_en = '0;
  logic prev_rst = 1'b0;
  int age[3];

  always #5 clk = ~clk;

  pwr_seq_top #(.RST_DLY_CYC(RST_DLY), .HOLD_WIN_CYC(HOLD_WIN)) uut (
    .clk(clk), .rst_n(rst_n), .wake_key(wake_key), .wake_hf(wake_hf),
    .wake_chg(wake_chg), .uvlo_ok(uvlo_ok), .tsd(tsd), .pgood(pg_r),
    .ext_en(ext_en), .host_hold(host_hold), .reg_en(reg_en),
    .rail_en(rail_en), .rst_out_n(rst_out_n), .key_n(key_n), .pwr_down(pwr_down)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // rail model: good two cycles after enable, unless forced bad
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      logic nxt;
      nxt = rail_en[i] && age[i] >= 2 && !fail_mask[i];
      if (i == 0 && nxt && !pg_r[0]) t_pg0 = cyc;
      pg_r[i] <= nxt;
      age[i] = rail_en[i] ? ((age[i] >= 3) ? 3 : age[i] + 1) : 0;
    end
    for (int i = 0; i < 7; i++) begin
      if (rail_en[i] && !prev_en[i]) t_rise[i] = cyc;
      if (!rail_en[i] && prev_en[i]) t_fall[i] = cyc;
    end
    if (rst_out_n && !prev_rst) t_rst = cyc;
    prev_en  = rail_en;
    prev_rst = rst_out_n;
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  function automatic logic [6:0] exp_run(input logic [2:0] ext, input logic [2:0] rb);
    return {rb[2], ext, rb[1], 1'b1, rb[0]};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_rst();
    for (int k = 0; k < 300 && !rst_out_n; k++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 3; i++) age[i] = 0;
    for (int i = 0; i < 7; i++) begin t_rise[i] = -1; t_fall[i] = -1; end
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R13 reset state
    check(rail_en == 0 && !rst_out_n && pwr_down, "R13", {rail_en, rst_out_n, pwr_down}, 1);

    // R1: no start under lockout
    wake_chg = 1'b1; ext_en = 3'b101;
    cycles(6);
    check(rail_en == 0, "R1", rail_en, 0);
    uvlo_ok = 1'b1;
    cycles(2);
    check(rail_en[0] == 1'b1, "R1", rail_en, 1);
    wait_rst();
    cycles(1);
    // R2 ordering
    check(t_rise[0] < t_rise[1] && t_rise[1] < t_rise[2], "R2", t_rise[1], t_rise[0] + 1);
    // R3 external rails with rail 2
    check(t_rise[3] == t_rise[2] && t_rise[5] == t_rise[2] && !rail_en[4], "R3", t_rise[3], t_rise[2]);
    // R4 reset delay from core good
    check(t_rst - t_pg0 == RST_DLY, "R4", t_rst - t_pg0, RST_DLY);
    // R7 before hold
    reg_en = 3'b100;
    cycles(3);
    check(rail_en == exp_run(3'b101, 3'b011), "R7", rail_en, exp_run(3'b101, 3'b011));
    host_hold = 1'b1;
    cycles(3);
    check(rail_en == exp_run(3'b101, 3'b100), "R7", rail_en, exp_run(3'b101, 3'b100));
    // R6: core off by register is no shutdown
    cycles(10);
    check(!pwr_down && rail_en[1], "R6", pwr_down, 0);

    // random pins, register bits and key
    for (int k = 0; k < 40; k++) begin
      logic [2:0] e, r;
      e = 3'($urandom); r = 3'($urandom);
      ext_en = e; reg_en = r; wake_key = 1'($urandom);
      cycles(2);
      check(rail_en == exp_run(e, r), "R3/R7", rail_en, exp_run(e, r));
      check(key_n == !wake_key, "R8", key_n, !wake_key);
    end

    // R6 core fault while enabled
    reg_en = 3'b111;
    cycles(8);
    fail_mask[0] = 1'b1;
    cycles(3);
    check(rail_en == 0 && pwr_down && !rst_out_n, "R6", rail_en, 0);
    // R12 lockout while a wake is still high
    cycles(10);
    check(rail_en == 0 && pwr_down, "R12", rail_en, 0);
    wake_chg = 1'b0; wake_key = 1'b0; fail_mask = '0; host_hold = 1'b0; ext_en = '0;
    cycles(3);
    wake_hf = 1'b1;
    cycles(2);
    check(rail_en[0] == 1'b1, "R12", rail_en, 1);

    // R10 hold window expiry
    wait_rst();
    cycles(HOLD_WIN - 3);
    check(!pwr_down && rail_en[1], "R10", pwr_down, 0);
    cycles(15);
    check(t_fall[1] == t_rst + HOLD_WIN + 3, "R10", t_fall[1] - t_rst, HOLD_WIN + 3);
    check(pwr_down && rail_en == 0, "R10", rail_en, 0);
    wake_hf = 1'b0;
    cycles(3);

    // R11 reverse shutdown
    wake_key = 1'b1; ext_en = 3'b111; reg_en = 3'b111;
    cycles(1);
    check(key_n == 1'b0, "R8", key_n, 0);
    wait_rst();
    host_hold = 1'b1;
    cycles(6);
    check(rail_en == 7'h7f, "R7", rail_en, 7'h7f);
    wake_key = 1'b0;
    cycles(1);
    host_hold = 1'b0;
    cycles(10);
    check(t_fall[3] == t_fall[6] && t_fall[4] == t_fall[6] && t_fall[5] == t_fall[6],
          "R11", t_fall[3], t_fall[6]);
    check(t_fall[2] == t_fall[6] + 1, "R11", t_fall[2], t_fall[6] + 1);
    check(t_fall[1] == t_fall[6] + 2, "R11", t_fall[1], t_fall[6] + 2);
    check(t_fall[0] == t_fall[6] + 3, "R11", t_fall[0], t_fall[6] + 3);
    check(pwr_down && rail_en == 0, "R11", rail_en, 0);

    // R5 logic rail loss
    wake_chg = 1'b1; ext_en = 3'b010;
    wait_rst();
    host_hold = 1'b1;
    cycles(4);
    fail_mask[1] = 1'b1;
    cycles(3);
    check(rail_en == 0 && pwr_down, "R5", rail_en, 0);
    wake_chg = 1'b0; fail_mask = '0; host_hold = 1'b0;
    cycles(3);

    // R9 thermal
    wake_key = 1'b1;
    wait_rst();
    check(rail_en != 0, "R9", rail_en, 1);
    tsd = 1'b1;
    cycles(1);
    check(rail_en == 0, "R9", rail_en, 0);
    cycles(5);
    check(rail_en == 0 && pwr_down, "R9", rail_en, 0);
    tsd = 1'b0; wake_key = 1'b0;
    cycles(3);
    check(pwr_down && !rst_out_n, "R13", pwr_down, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule